// File: doc/BRIEF.md
# GF(2^8) Bit-Parallel Field Multiplier

This block multiplies two bytes as elements of the finite field GF(2^8). Each byte is a polynomial over GF(2) with bit 0 as the constant term. The product is reduced by the fixed primitive polynomial x^8+x^4+x^3+x^2+1, which is 0x11D in full. This is the multiplier that sits inside Reed-Solomon encoders and syndrome or error-locator datapaths. A full product is ready every cycle.

The arithmetic runs in two stages. The first stage ANDs operand bit pairs and XORs them into two vectors. One is an 8-entry low-order vector that holds the product terms of degree 0 to 7. The other is a 7-entry overflow vector that holds the terms of degree 8 to 14. Neither vector depends on the polynomial. The second stage folds each overflow bit back into the low-order bits through a constant 0/1 matrix. Row j of that matrix is x^(8+j) mod P(x), and it is worked out when the design elaborates.

A parameter can add one output register stage. It is on by default. With the register on, a result and its valid flag appear one cycle after the operands are accepted. With it off, the path is purely combinational.

Top module: `gf_byte_multiplier`

## Requirements
- R1: With the output register enabled, `product` equals the carry-less product of `opA` and `opB` reduced modulo 0x11D, for every one of the 65,536 operand pairs. It is presented in the cycle after `inValid` was high with those operands.
- R2: When either operand is 0x00, the product is 0x00.
- R3: When one operand is 0x01, the product equals the other operand.
- R4: Swapping `opA` and `opB` never changes the product.
- R5: `outValid` is high in a cycle exactly when `inValid` was high in the cycle before. Otherwise it is low.
- R6: While `inValid` is low, `product` keeps its last registered value whatever the operands do.
- R7: While `rstN` is low, and right after it is released, `outValid` is 0 and `product` is 0x00.
- R8: Reduction is applied: 0x02 times 0x80 (x times x^7) gives 0x1D, and 0x80 times 0x80 (x^14) gives 0x13.
- R9: Back-to-back operand pairs, with `inValid` high on consecutive cycles, each produce their own result on consecutive cycles with no bubble.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Operands on `opA`/`opB` are to be accepted this cycle |
| opA | input | 8 | First field element |
| opB | input | 8 | Second field element |
| outValid | output | 1 | `product` holds a fresh result |
| product | output | 8 | Reduced field product |

## Verification
Loading a new result and presenting the previous one fall in the same cycle when operand pairs stream back to back. At each falling edge the bench checks the result of the pair driven one cycle earlier, then drives the next pair at once, so every product is judged while its successor is being captured. Holding also meets changing operands: the bench drops `inValid` and scrambles the operands in the same cycle. It then requires the old product to stay and `outValid` to fall.

// File: rtl/gf_mul_pkg.sv
package gf_mul_pkg;
  localparam int FIELD_W = 8;
  localparam logic [FIELD_W:0] FIELD_POLY = 9'h11D;

  typedef struct packed {
    logic loadEn;
  } gfStrobes_t;
endpackage

// File: rtl/gf_partial_prod.sv
module gf_partial_prod #(
  parameter int W = gf_mul_pkg::FIELD_W
) (
  input  logic [W-1:0] aIn,
  input  logic [W-1:0] bIn,
  output logic [W-1:0] lowVec,
  output logic [W-2:0] highVec
);
  // Low-order terms: degree k collects a[i]*b[k-i] for i = 0..k
  always_comb begin
    for (int k = 0; k < W; k++) begin
      logic acc;
      acc = 1'b0;
      for (int i = 0; i <= k; i++) begin
        acc = acc ^ (aIn[i] & bIn[k-i]);
      end
      lowVec[k] = acc;
    end
  end

  // Overflow terms: degree W+k collects a[i]*b[W+k-i] for i = k+1..W-1
  always_comb begin
    for (int k = 0; k < W-1; k++) begin
      logic acc;
      acc = 1'b0;
      for (int i = k + 1; i < W; i++) begin
        acc = acc ^ (aIn[i] & bIn[W+k-i]);
      end
      highVec[k] = acc;
    end
  end
endmodule

// File: rtl/gf_reduce_fold.sv
module gf_reduce_fold #(
  parameter int W = gf_mul_pkg::FIELD_W,
  parameter logic [W:0] POLY = gf_mul_pkg::FIELD_POLY
) (
  input  logic [W-1:0] lowVec,
  input  logic [W-2:0] highVec,
  output logic [W-1:0] result
);
  // x^n mod POLY, evaluated at elaboration to build the fold matrix
  function automatic logic [W-1:0] powerRow(input int n);
    logic [W-1:0] r;
    r = {{(W-1){1'b0}}, 1'b1};
    for (int s = 0; s < n; s++) begin
      if (r[W-1]) r = (r << 1) ^ POLY[W-1:0];
      else        r = r << 1;
    end
    return r;
  endfunction

  for (genvar k = 0; k < W; k++) begin : g_outBit
    logic [W-2:0] colMask;
    for (genvar j = 0; j < W-1; j++) begin : g_row
      localparam logic [W-1:0] ROW = powerRow(W + j);
      assign colMask[j] = ROW[k];
    end
    assign result[k] = lowVec[k] ^ (^(highVec & colMask));
  end
endmodule

// File: rtl/gf_mul_ctrl.sv
module gf_mul_ctrl
  import gf_mul_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  output gfStrobes_t strobes,
  output logic       outValid
);
  assign strobes.loadEn = inValid;

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) outValid <= 1'b0;
      else       outValid <= inValid;
    end

    // R5
    valid_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
      inValid |=> outValid);
    // R5
    valid_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
      !inValid |=> !outValid);
  end else begin : g_comb
    assign outValid = inValid;
  end
endmodule

// File: rtl/gf_mul_datapath.sv
module gf_mul_datapath
  import gf_mul_pkg::*;
#(
  parameter int W = FIELD_W,
  parameter logic [W:0] POLY = FIELD_POLY,
  parameter bit REG_OUT = 1'b1
) (
  input  logic         clk,
  input  logic         rstN,
  input  gfStrobes_t   strobes,
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  output logic [W-1:0] product
);
  logic [W-1:0] lowVec;
  logic [W-2:0] highVec;
  logic [W-1:0] rawProd;

  gf_partial_prod #(.W(W)) pp_i (
    .aIn(opA), .bIn(opB), .lowVec(lowVec), .highVec(highVec)
  );

  gf_reduce_fold #(.W(W), .POLY(POLY)) fold_i (
    .lowVec(lowVec), .highVec(highVec), .result(rawProd)
  );

  // R2
  zero_operand_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((opA == '0) || (opB == '0)) |-> (rawProd == '0));
  // R3
  unit_operand_chk: assert property (@(posedge clk) disable iff (!rstN)
    (opA == W'(1)) |-> (rawProd == opB));

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)              product <= '0;
      else if (strobes.loadEn) product <= rawProd;
    end

    // R6
    hold_product_chk: assert property (@(posedge clk) disable iff (!rstN)
      !strobes.loadEn |=> $stable(product));
  end else begin : g_comb
    assign product = rawProd;
  end
endmodule

// File: rtl/gf_byte_multiplier.sv
module gf_byte_multiplier
  import gf_mul_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         inValid,
  input  logic [7:0]   opA,
  input  logic [7:0]   opB,
  output logic         outValid,
  output logic [7:0]   product
);
  gfStrobes_t strobes;

  gf_mul_ctrl #(.REG_OUT(REG_OUT)) ctrl_i (
    .clk(clk), .rstN(rstN), .inValid(inValid),
    .strobes(strobes), .outValid(outValid)
  );

  gf_mul_datapath #(.W(FIELD_W), .POLY(FIELD_POLY), .REG_OUT(REG_OUT)) dp_i (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .opA(opA), .opB(opB), .product(product)
  );
endmodule

// File: tb/gf_byte_multiplier_tb.sv
module gf_byte_multiplier_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       inValid = 1'b0;
  logic [7:0] opA = 8'h00;
  logic [7:0] opB = 8'h00;
  logic       outValid;
  logic [7:0] product;

  int checkCount = 0;
  int failCount = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gf_byte_multiplier dut_i (
    .clk(clk), .rstN(rstN), .inValid(inValid),
    .opA(opA), .opB(opB), .outValid(outValid), .product(product)
  );

  function automatic logic [7:0] refMul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] acc;
    logic [7:0] sh;
    acc = 8'h00;
    sh = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) acc = acc ^ sh;
      if (sh[7]) sh = (sh << 1) ^ 8'h1D;
      else       sh = sh << 1;
    end
    return acc;
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checkCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  // one pair: drive at falling edge, captured at the rising edge, read at next falling edge
  task automatic applyOne(input logic [7:0] a, input logic [7:0] b, output logic [7:0] res);
    @(negedge clk);
    opA = a; opB = b; inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    res = product;
  endtask

  task automatic testReset();
    @(negedge clk);
    check("R7 outValid in reset", {7'b0, outValid}, 8'h00);
    check("R7 product in reset", product, 8'h00);
    rstN = 1'b1;
    @(negedge clk);
    check("R7 outValid after reset", {7'b0, outValid}, 8'h00);
    check("R7 product after reset", product, 8'h00);
  endtask

  task automatic testReduction();
    logic [7:0] r;
    applyOne(8'h02, 8'h80, r);
    check("R8 x*x^7", r, 8'h1D);
    applyOne(8'h80, 8'h80, r);
    check("R8 x^7*x^7", r, 8'h13);
  endtask

  task automatic testZeroAndOne();
    logic [7:0] r;
    for (int v = 0; v < 256; v += 17) begin
      applyOne(8'(v), 8'h00, r);
      check("R2 b zero", r, 8'h00);
      applyOne(8'h00, 8'(v), r);
      check("R2 a zero", r, 8'h00);
      applyOne(8'h01, 8'(v), r);
      check("R3 a one", r, 8'(v));
      applyOne(8'(v), 8'h01, r);
      check("R3 b one", r, 8'(v));
    end
  endtask

  task automatic testCommute();
    logic [7:0] r1;
    logic [7:0] r2;
    for (int k = 0; k < 32; k++) begin
      logic [7:0] a;
      logic [7:0] b;
      a = 8'(k * 37 + 5);
      b = 8'(k * 91 + 200);
      applyOne(a, b, r1);
      applyOne(b, a, r2);
      check("R4 swapped operands", r2, r1);
    end
  endtask

  task automatic testValidAndHold();
    logic [7:0] r;
    applyOne(8'h57, 8'h83, r);
    check("R5 outValid after accept", {7'b0, outValid}, 8'h01);
    opA = 8'hFF; opB = 8'hEE;
    @(negedge clk);
    check("R5 outValid drops", {7'b0, outValid}, 8'h00);
    check("R6 hold with scrambled operands", product, refMul(8'h57, 8'h83));
    opA = 8'h12; opB = 8'h34;
    @(negedge clk);
    check("R6 hold second cycle", product, refMul(8'h57, 8'h83));
  endtask

  // streaming: every pair back to back, result of the previous pair judged while the next is driven
  task automatic testExhaustive();
    logic [7:0] expPrev;
    bit havePrev;
    havePrev = 1'b0;
    expPrev = 8'h00;
    for (int a = 0; a < 256; a++) begin
      for (int b = 0; b < 256; b++) begin
        @(negedge clk);
        if (havePrev) begin
          check("R1 exhaustive product", product, expPrev);
          if (outValid !== 1'b1) check("R9 valid while streaming", {7'b0, outValid}, 8'h01);
        end
        opA = 8'(a); opB = 8'(b); inValid = 1'b1;
        expPrev = refMul(8'(a), 8'(b));
        havePrev = 1'b1;
      end
    end
    @(negedge clk);
    inValid = 1'b0;
    check("R1 last pair", product, expPrev);
    check("R9 last valid", {7'b0, outValid}, 8'h01);
  endtask

  initial begin
    testReset();
    testReduction();
    testZeroAndOne();
    testCommute();
    testValidAndHold();
    testExhaustive();
    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checkCount, failCount);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checkCount++;
      failCount++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checkCount, failCount);
      $finish;
    end
  end
endmodule